// File: doc/BRIEF.md
# Triggered Interval Timer with Pulse-Width Abort

This block is an up-counting interval timer with two operating modes. In the free-running mode it counts the ticks of a source-clock enable. When the count would reach a programmable compare value, it raises a one-cycle interrupt, returns the count to zero and keeps going. A software capture strobe copies the live count into a capture register at any time, and the strobe does not disturb counting.

In the triggered mode the timer sits idle at zero until an edge of the selected polarity arrives on an already-filtered input pin. It then counts ticks. When the compare value is reached it interrupts, clears and halts until the next trigger edge. Trigger edges seen while counting have no effect. With the width-abort option set, an edge of the opposite direction while counting clears and halts the timer without an interrupt. An interrupt then marks only those input pulses that last at least the compare interval. The prescaler that makes the tick enable, and the register access to the controls, lie outside the block.

Top module: `trig_timer`

## Requirements
- R1: While `srst` is high at a clock edge, the count clears to 0 and the timer halts. After that edge `irq` is 0 and `cap_q` is 0.
- R2: With `run_en`=1 and `ext_mode`=0, the count advances by one on each edge where `tick_en`=1 and holds otherwise. On the tick where the advanced count would equal `cmp_val`, the count becomes 0, counting continues, and `irq` is 1 for the following cycle. So one interrupt is raised every `cmp_val` ticks.
- R3: A `cmp_val` of 0 gives a period of 65536 ticks.
- R4: When `cap_stb`=1 at an edge, `cap_q` takes the count held just before that edge. Counting is unaffected. Otherwise `cap_q` holds its value.
- R5: With `run_en`=1 and `ext_mode`=1, the timer stays at 0 until a trigger edge. An edge is a difference between `pin_lvl` and its value at the previous clock edge. `fall_sel`=0 selects a 0-to-1 trigger and `fall_sel`=1 selects 1-to-0. Ticks are counted from the edge after the trigger.
- R6: In triggered mode a compare match clears the count to 0, pulses `irq` and halts the timer. The next trigger edge restarts it.
- R7: Trigger edges that arrive while the triggered count is running do not restart or alter it.
- R8: With `width_clr`=1, an edge opposite to the trigger polarity while counting clears the count and halts the timer with no interrupt. If a match happens in the same cycle, the match wins.
- R9: With `width_clr`=0, opposite edges have no effect on the count.
- R10: With `run_en`=0, the count is held at 0 and halted. In any cycle where `run_en` or `ext_mode` differs from its value at the previous edge, the count clears and halts with no interrupt.
- R11: `irq` is high for exactly one cycle per match. The count reads 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Source-clock tick enable |
| pin_lvl | input | 1 | Filtered trigger pin level |
| fall_sel | input | 1 | Trigger polarity: 0 rising, 1 falling |
| run_en | input | 1 | Timer enable |
| ext_mode | input | 1 | 0 free-running, 1 triggered |
| width_clr | input | 1 | Opposite edge aborts the count |
| cap_stb | input | 1 | Software capture strobe |
| cmp_val | input | CNT_W | Compare value (0 means 2^CNT_W) |
| irq | output | 1 | Interrupt pulse |
| cap_q | output | CNT_W | Captured count |

## Verification
The bench sends pulses narrower and wider than the compare interval with the abort option on and off. A design that ignored the abort would fire on short pulses, and one that never cleared would miss wide pulses. It re-triggers during a running count and flips the polarity, so a timer that restarts on every edge, or detects the wrong direction, shifts or duplicates interrupts. Compare values of 1 and 0 probe the wrap. An off-by-one compare or a zero value taken literally shows up as a wrong period across the full 65536-tick run. Strobed captures during counting expose a count that fails to hold when ticks are absent or that is disturbed by a mode change.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_TRIG = 1'b1
    } tmode_e;

    typedef struct packed {
        logic   run;
        tmode_e mode;
    } tcfg_t;
endpackage

// File: rtl/tt_edge_det.sv
module tt_edge_det (
    input  logic clk,
    input  logic pin_lvl,
    input  logic fall_sel,
    output logic trig_o,
    output logic opp_o
);
    typedef struct packed {
        logic pin;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise_w, fall_w;

    always_comb begin
        st_d.pin = pin_lvl;
        rise_w   = ~st_q.pin & pin_lvl;
        fall_w   = st_q.pin & ~pin_lvl;
        trig_o   = fall_sel ? fall_w : rise_w;
        opp_o    = fall_sel ? rise_w : fall_w;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
    import tt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             tick_en,
    input  tcfg_t            cfg,
    input  logic             width_clr,
    input  logic             trig,
    input  logic             opp,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             act_o,
    output logic             cfg_chg_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
        tcfg_t            cfg;
        logic             irq;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] nxt_w;
    logic             hit_w;
    logic             chg_w;

    always_comb begin
        nxt_w = st_q.cnt + ONE;
        hit_w = tick_en && (nxt_w == cmp_val);
        chg_w = (cfg != st_q.cfg);

        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.cfg = cfg;

        if (srst || chg_w || !cfg.run) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end else if (cfg.mode == MODE_FREE) begin
            st_d.act = 1'b0;
            if (hit_w) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else if (tick_en) begin
                st_d.cnt = nxt_w;
            end
        end else if (!st_q.act) begin
            if (trig) begin
                st_d.act = 1'b1;
            end
        end else if (hit_w) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
            st_d.irq = 1'b1;
        end else if (width_clr && opp) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end else if (tick_en) begin
            st_d.cnt = nxt_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign act_o     = st_q.act;
    assign irq_o     = st_q.irq;
    assign cfg_chg_o = chg_w;
endmodule

// File: rtl/tt_capture.sv
module tt_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             cap_stb,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.cap = '0;
        end else if (cap_stb) begin
            st_d.cap = cnt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap_o = st_q.cap;
endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import tt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             tick_en,
    input  logic             pin_lvl,
    input  logic             fall_sel,
    input  logic             run_en,
    input  logic             ext_mode,
    input  logic             width_clr,
    input  logic             cap_stb,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             irq,
    output logic [CNT_W-1:0] cap_q
);
    tcfg_t            cfg_w;
    logic             trig_w, opp_w;
    logic [CNT_W-1:0] cnt_w;
    logic             act_w, cfg_chg_w;

    assign cfg_w.run  = run_en;
    assign cfg_w.mode = ext_mode ? MODE_TRIG : MODE_FREE;

    tt_edge_det u_edge (
        .clk      (clk),
        .pin_lvl  (pin_lvl),
        .fall_sel (fall_sel),
        .trig_o   (trig_w),
        .opp_o    (opp_w)
    );

    tt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .srst      (srst),
        .tick_en   (tick_en),
        .cfg       (cfg_w),
        .width_clr (width_clr),
        .trig      (trig_w),
        .opp       (opp_w),
        .cmp_val   (cmp_val),
        .cnt_o     (cnt_w),
        .act_o     (act_w),
        .cfg_chg_o (cfg_chg_w),
        .irq_o     (irq)
    );

    tt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .srst    (srst),
        .cap_stb (cap_stb),
        .cnt     (cnt_w),
        .cap_o   (cap_q)
    );
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             srst,
    input logic             tick_en,
    input logic             run_en,
    input logic             ext_mode,
    input logic             width_clr,
    input logic             cap_stb,
    input logic             irq,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] cnt,
    input logic             act,
    input logic             cfg_chg,
    input logic             opp
);
    // R2
    free_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (run_en && !ext_mode && !cfg_chg && !tick_en) |=> $stable(cnt));

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (srst)
        cap_stb |=> (cap_q == $past(cnt)));

    // R6
    trig_halt_chk: assert property (@(posedge clk) disable iff (srst)
        (irq && ext_mode && run_en) |-> !act);

    // R8
    width_abort_chk: assert property (@(posedge clk) disable iff (srst)
        (run_en && ext_mode && !cfg_chg && act && width_clr && opp && !tick_en)
        |=> (!act && cnt == '0 && !irq));

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (srst)
        (!run_en || cfg_chg) |=> (cnt == '0 && !act && !irq));

    // R11
    irq_zero_chk: assert property (@(posedge clk) disable iff (srst)
        irq |-> (cnt == '0));
endmodule

bind trig_timer tt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .srst      (srst),
    .tick_en   (tick_en),
    .run_en    (run_en),
    .ext_mode  (ext_mode),
    .width_clr (width_clr),
    .cap_stb   (cap_stb),
    .irq       (irq),
    .cap_q     (cap_q),
    .cnt       (cnt_w),
    .act       (act_w),
    .cfg_chg   (cfg_chg_w),
    .opp       (opp_w)
);

// File: tb/trig_timer_tb.sv
module trig_timer_tb_top;
    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        tick_en = 1'b0;
    logic        pin_lvl = 1'b0;
    logic        fall_sel = 1'b0;
    logic        run_en = 1'b0;
    logic        ext_mode = 1'b0;
    logic        width_clr = 1'b0;
    logic        cap_stb = 1'b0;
    logic [15:0] cmp_val = 16'd5;
    logic        irq;
    logic [15:0] cap_q;

    always #2 clk = ~clk;

    trig_timer #(.CNT_W(16)) dut_i (
        .clk(clk), .srst(srst), .tick_en(tick_en), .pin_lvl(pin_lvl),
        .fall_sel(fall_sel), .run_en(run_en), .ext_mode(ext_mode),
        .width_clr(width_clr), .cap_stb(cap_stb), .cmp_val(cmp_val),
        .irq(irq), .cap_q(cap_q)
    );

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    int    irq_seen = 0;
    string tag = "R1";
    bit    auto_cap = 0;
    int    tick_mode = 0;

    // behavioural reference state
    int m_cnt = 0;
    bit m_act = 0, m_irq = 0, m_pin = 0, m_run = 0, m_ext = 0;
    int m_cap = 0;

    task automatic model_edge();
        bit rise, fall, trig, opp;
        int lim;
        int old_cnt;
        old_cnt = m_cnt;
        rise = !m_pin && pin_lvl;
        fall = m_pin && !pin_lvl;
        trig = fall_sel ? fall : rise;
        opp  = fall_sel ? rise : fall;
        lim  = (cmp_val == 16'd0) ? 65536 : int'(cmp_val);
        m_irq = 0;
        if (srst) begin
            m_cnt = 0; m_act = 0; m_cap = 0;
        end else begin
            if (cap_stb) m_cap = old_cnt;
            if (run_en != m_run || ext_mode != m_ext || !run_en) begin
                m_cnt = 0; m_act = 0;
            end else if (!ext_mode) begin
                if (tick_en) begin
                    if (m_cnt + 1 == lim || (m_cnt + 1) % 65536 == lim % 65536 && lim != 65536) begin
                        m_cnt = 0; m_irq = 1;
                    end else if (m_cnt + 1 == 65536 && lim == 65536) begin
                        m_cnt = 0; m_irq = 1;
                    end else begin
                        m_cnt = (m_cnt + 1) % 65536;
                    end
                end
            end else if (!m_act) begin
                if (trig) m_act = 1;
            end else if (tick_en && ((m_cnt + 1) % 65536 == lim % 65536)) begin
                m_cnt = 0; m_act = 0; m_irq = 1;
            end else if (width_clr && opp) begin
                m_cnt = 0; m_act = 0;
            end else if (tick_en) begin
                m_cnt = m_cnt + 1;
            end
        end
        m_pin = pin_lvl;
        m_run = run_en;
        m_ext = ext_mode;
    endtask

    task automatic step();
        if (auto_cap) cap_stb = (cycles % 3 == 0);
        else cap_stb = 0;
        if (tick_mode == 0) tick_en = 1;
        else if (tick_mode == 1) tick_en = (cycles % 3 != 1);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cycles++;
        vectors++;
        if (irq !== m_irq || cap_q !== m_cap[15:0]) begin
            fails++;
            $display("FAIL %s cycle %0d: irq=%b exp=%b cap=%0d exp=%0d",
                     tag, cycles, irq, m_irq, cap_q, m_cap);
        end
        if (irq === 1'b1) irq_seen++;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check_irqs(input string t, input int exp);
        vectors++;
        if (irq_seen != exp) begin
            fails++;
            $display("FAIL %s irq count=%0d exp=%0d", t, irq_seen, exp);
        end
        irq_seen = 0;
    endtask

    task automatic pulse(input int w, input int gap);
        pin_lvl = !fall_sel;
        cyc(w);
        pin_lvl = fall_sel;
        cyc(gap);
    endtask

    initial begin
        @(negedge clk);
        tag = "R1";
        cyc(3);
        vectors++;
        if (irq !== 1'b0 || cap_q !== 16'd0) begin
            fails++;
            $display("FAIL R1 reset irq=%b exp=0 cap=%0d exp=0", irq, cap_q);
        end
        srst = 0;

        tag = "R2"; run_en = 1; cmp_val = 16'd5; auto_cap = 1;
        irq_seen = 0;
        cyc(31);                       // clear cycle + 30 ticks -> 6 periods
        check_irqs("R2", 6);
        tick_mode = 1; cyc(40);
        tag = "R4"; tick_mode = 2; tick_en = 0; cyc(10);
        tick_mode = 0; cmp_val = 16'd1; tag = "R11"; cyc(10);

        tag = "R10"; run_en = 0; irq_seen = 0; cyc(12);
        check_irqs("R10", 0);

        tag = "R3"; auto_cap = 0; cmp_val = 16'd0; run_en = 1; irq_seen = 0;
        cyc(65540);
        check_irqs("R3", 1);

        // triggered mode
        tag = "R5"; ext_mode = 1; cmp_val = 16'd8; width_clr = 1;
        fall_sel = 0; pin_lvl = 0; auto_cap = 1;
        cyc(20); irq_seen = 0;
        check_irqs("R5", 0);
        tag = "R8"; pulse(3, 15);
        check_irqs("R8", 0);
        tag = "R6"; pulse(20, 15);
        check_irqs("R6", 1);
        pulse(20, 15);
        check_irqs("R6", 1);
        tag = "R9"; width_clr = 0;
        pulse(3, 15);
        check_irqs("R9", 1);
        tag = "R7"; pulse(2, 2); pulse(2, 20);
        check_irqs("R7", 1);

        tag = "R5"; fall_sel = 1; pin_lvl = 1; width_clr = 1;
        cyc(12); irq_seen = 0;
        pulse(4, 15);
        check_irqs("R5", 0);
        pulse(12, 15);
        check_irqs("R5", 1);
        tag = "R8"; tick_mode = 1; pulse(10, 20);
        pulse(13, 20);
        tag = "R10"; ext_mode = 0; cyc(5); ext_mode = 1; cyc(5);
        tag = "R1"; srst = 1; cyc(3); srst = 0; cyc(5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule